// File: doc/BRIEF.md
# Posted-CAS Data Window Scheduler

This block sits on the controller side of a double-data-rate memory channel and works out, for each read or write command sent to the device, the clock cycle in which that command's data burst occupies the data bus. Read latency is the programmed additive latency plus the programmed CAS latency. Write latency is one cycle less than read latency. A read may therefore be posted early, before the activate-to-read delay has run out, and a write may follow a read directly once its window no longer collides with the read data.

Commands arrive as a valid/ready stream with a two-bit opcode. A command transfers on a rising edge where both `cmd_valid` and `cmd_ready` are high. While `cmd_ready` is low the source must hold the command and its opcode unchanged. Up to four data commands are tracked at once in countdown slots. The outputs mark the read-data-valid window and the write-data-enable window, and give the index of the first beat carried in the current cycle. Two beats move per clock, so a burst occupies half its length in cycles. Latency and burst settings are taken from the configuration pins only while nothing is outstanding.

Top module: `ddr2_cas_scheduler`

## Requirements
- R1: Opcode encoding is 0 = no-op, 1 = activate, 2 = read, 3 = write. An accepted read accepted at rising edge k drives `rd_valid` high from the cycle after edge k+RL. RL is `cfg_al` plus `cfg_cl`, and a `cfg_cl` value below 2 counts as 2.
- R2: An accepted write accepted at edge k drives `wr_en` high from the cycle after edge k+RL-1.
- R3: Each window lasts exactly 2 cycles when `cfg_bl8` is 0 (burst of 4) and 4 cycles when it is 1 (burst of 8).
- R4: During a window, `beat_idx` gives the index of the first beat in that cycle: 0, 2, 4, 6 in turn. Outside every window it is 0.
- R5: A read or write whose window would overlap any window still pending is dropped. No window is produced for it, and `conflict` is high for exactly the one cycle after its accepting edge.
- R6: A window may start in the cycle right after another ends. A write issued after a read under these conditions is accepted without conflict.
- R7: `cmd_ready` is low exactly while four data commands are outstanding, from the cycle after acceptance through the last cycle of the window. It is high otherwise, including during reset.
- R8: The latency and burst inputs are sampled only in cycles with no outstanding command. Changes made while a command is outstanding have no effect on commands accepted before the block next goes idle.
- R9: Accepted activate and no-op commands produce no window and no conflict.
- R10: During reset `rd_valid`, `wr_en`, `conflict` and `beat_idx` are 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 2 | Opcode: 0 no-op, 1 activate, 2 read, 3 write |
| cfg_al | input | 3 | Additive latency in cycles |
| cfg_cl | input | 3 | CAS latency in cycles (minimum 2) |
| cfg_bl8 | input | 1 | 1 selects burst of 8, 0 burst of 4 |
| rd_valid | output | 1 | Read data window active |
| wr_en | output | 1 | Write data window active |
| beat_idx | output | 3 | First beat index of the current cycle |
| conflict | output | 1 | One-cycle pulse for a dropped colliding command |

## Verification
A read's window is due RL rising edges after the edge that accepts it, and a write's window RL-1 edges after. `conflict` is due one cycle after the accepting edge, while `cmd_ready` reflects the occupancy of the current cycle. The bench keeps expected bus state in a table indexed by cycle number. It fills that table at the moment a command is driven, using the latched settings of its own model, and compares every output at each falling edge against the entry for that cycle. Directed sequences then confirm the exact cycle of the first read and write beats, the window lengths, and that settings changed mid-flight are ignored.

// File: rtl/ddr2_sched_pkg.sv
package ddr2_sched_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_ACT = 2'd1,
    OP_RD  = 2'd2,
    OP_WR  = 2'd3
  } cmd_op_e;

  localparam int LEN_W  = 3;  // burst length in bus cycles, up to 4
  localparam int BEAT_W = 3;  // beat index 0..7
endpackage

// File: rtl/ddr2_lat_cfg.sv
// Holds the latency settings steady while commands are in flight.
module ddr2_lat_cfg import ddr2_sched_pkg::*; #(
  parameter int AL_W  = 3,
  parameter int CL_W  = 3,
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic [AL_W-1:0]  cfg_al,
  input  logic [CL_W-1:0]  cfg_cl,
  input  logic             cfg_bl8,
  output logic [LAT_W-1:0] rd_lat,
  output logic [LAT_W-1:0] wr_lat,
  output logic [LEN_W-1:0] burst_len,
  output logic             bl8_eff
);
  localparam logic [CL_W-1:0] CL_MIN = CL_W'(2);

  logic [AL_W-1:0] al_q, al_e;
  logic [CL_W-1:0] cl_q, cl_e, cl_c;
  logic            bl8_q;

  always_comb begin
    al_e    = idle ? cfg_al  : al_q;
    cl_e    = idle ? cfg_cl  : cl_q;
    bl8_eff = idle ? cfg_bl8 : bl8_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      al_q  <= '0;
      cl_q  <= CL_W'(3);
      bl8_q <= 1'b0;
    end else begin
      al_q  <= al_e;
      cl_q  <= cl_e;
      bl8_q <= bl8_eff;
    end
  end

  assign cl_c      = (cl_e < CL_MIN) ? CL_MIN : cl_e;
  assign rd_lat    = LAT_W'(al_e) + LAT_W'(cl_c);
  assign wr_lat    = rd_lat - LAT_W'(1);
  assign burst_len = bl8_eff ? LEN_W'(4) : LEN_W'(2);
endmodule

// File: rtl/ddr2_burst_slot.sv
// One outstanding command: counts down its latency, then its burst cycles.
module ddr2_burst_slot import ddr2_sched_pkg::*; #(
  parameter int LAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LAT_W-1:0]  load_lat,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              load_wr,
  output logic              busy,
  output logic              active,
  output logic              is_wr,
  output logic [BEAT_W-1:0] beat,
  output logic [LAT_W-1:0]  rem_start,
  output logic [LEN_W-1:0]  rem_len
);
  logic [LAT_W-1:0] cnt;
  logic [LEN_W-1:0] len, tot, done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      len   <= '0;
      tot   <= '0;
      is_wr <= 1'b0;
    end else if (load) begin
      cnt   <= load_lat;
      len   <= load_len;
      tot   <= load_len;
      is_wr <= load_wr;
    end else if (cnt != '0) begin
      cnt <= cnt - LAT_W'(1);
    end else if (len != '0) begin
      len <= len - LEN_W'(1);
    end
  end

  assign busy   = (len != '0);
  assign active = busy && (cnt == '0);
  assign done   = tot - len;
  assign beat   = {done[BEAT_W-2:0], 1'b0};

  // Window still owed after the coming edge, as offsets from that edge.
  always_comb begin
    if (cnt != '0) begin
      rem_start = cnt - LAT_W'(1);
      rem_len   = len;
    end else begin
      rem_start = '0;
      rem_len   = busy ? len - LEN_W'(1) : '0;
    end
  end
endmodule

// File: rtl/ddr2_window_guard.sv
// Compares a candidate data window against every pending one.
module ddr2_window_guard import ddr2_sched_pkg::*; #(
  parameter int NSLOT = 4,
  parameter int LAT_W = 4
) (
  input  logic [LAT_W-1:0] rem_start [NSLOT],
  input  logic [LEN_W-1:0] rem_len   [NSLOT],
  input  logic [LAT_W-1:0] new_start,
  input  logic [LEN_W-1:0] new_len,
  output logic             clash
);
  localparam int SW = LAT_W + 2;

  logic [NSLOT-1:0] hit;

  for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
    logic [SW-1:0] s_beg, s_end, n_beg, n_end;
    assign s_beg  = SW'(rem_start[g]);
    assign s_end  = SW'(rem_start[g]) + SW'(rem_len[g]);
    assign n_beg  = SW'(new_start);
    assign n_end  = SW'(new_start) + SW'(new_len);
    assign hit[g] = (rem_len[g] != '0) && (n_beg < s_end) && (s_beg < n_end);
  end

  assign clash = |hit;
endmodule

// File: rtl/ddr2_cas_scheduler.sv
module ddr2_cas_scheduler import ddr2_sched_pkg::*; #(
  parameter int NSLOT = 4,
  parameter int AL_W  = 3,
  parameter int CL_W  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [1:0]  cmd_op,
  input  logic [2:0]  cfg_al,
  input  logic [2:0]  cfg_cl,
  input  logic        cfg_bl8,
  output logic        rd_valid,
  output logic        wr_en,
  output logic [2:0]  beat_idx,
  output logic        conflict
);
  localparam int LAT_W = $clog2((1 << AL_W) + (1 << CL_W));

  logic             idle, bl8_eff, clash, is_data, accept;
  logic [LAT_W-1:0] rd_lat, wr_lat, new_lat;
  logic [LEN_W-1:0] burst_len;
  logic [NSLOT-1:0] s_busy, s_act, s_wr, sel_oh;
  logic [LAT_W-1:0] s_rstart [NSLOT];
  logic [LEN_W-1:0] s_rlen   [NSLOT];
  logic [BEAT_W-1:0] s_beat  [NSLOT];
  cmd_op_e          op;

  assign op = cmd_op_e'(cmd_op);

  ddr2_lat_cfg #(.AL_W(AL_W), .CL_W(CL_W), .LAT_W(LAT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .idle(idle),
    .cfg_al(AL_W'(cfg_al)), .cfg_cl(CL_W'(cfg_cl)), .cfg_bl8(cfg_bl8),
    .rd_lat(rd_lat), .wr_lat(wr_lat), .burst_len(burst_len), .bl8_eff(bl8_eff)
  );

  assign is_data = (op == OP_RD) || (op == OP_WR);
  assign new_lat = (op == OP_WR) ? wr_lat : rd_lat;

  ddr2_window_guard #(.NSLOT(NSLOT), .LAT_W(LAT_W)) u_guard (
    .rem_start(s_rstart), .rem_len(s_rlen),
    .new_start(new_lat), .new_len(burst_len), .clash(clash)
  );

  // Lowest-numbered free slot takes the next command.
  always_comb begin
    logic found;
    found  = 1'b0;
    sel_oh = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (!s_busy[i] && !found) begin
        sel_oh[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  assign idle      = ~|s_busy;
  assign cmd_ready = ~&s_busy;
  assign accept    = cmd_valid && cmd_ready && is_data && !clash;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    ddr2_burst_slot #(.LAT_W(LAT_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .load(accept && sel_oh[g]),
      .load_lat(new_lat), .load_len(burst_len), .load_wr(op == OP_WR),
      .busy(s_busy[g]), .active(s_act[g]), .is_wr(s_wr[g]),
      .beat(s_beat[g]), .rem_start(s_rstart[g]), .rem_len(s_rlen[g])
    );
  end

  always_comb begin
    beat_idx = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (s_act[i]) beat_idx = beat_idx | s_beat[i];
    end
  end

  assign rd_valid = |(s_act & ~s_wr);
  assign wr_en    = |(s_act & s_wr);

  always_ff @(posedge clk) begin
    if (!rst_n) conflict <= 1'b0;
    else        conflict <= cmd_valid && cmd_ready && is_data && clash;
  end
endmodule

// File: rtl/ddr2_cas_sched_chk.sv
module ddr2_cas_sched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic       rd_valid,
  input logic       wr_en,
  input logic [2:0] beat_idx,
  input logic       conflict,
  input logic       bl8_eff,
  input logic       idle,
  input logic [3:0] rd_lat
);
  // R5: windows never collide on the bus
  p_no_bus_clash_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_en));

  // R4: beats advance by two within one window
  p_beat_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_valid || wr_en) && beat_idx != 3'd0) |->
      ($past(rd_valid || wr_en) && beat_idx == 3'($past(beat_idx) + 3'd2)));

  // R3: a burst of four never reaches beat 4
  p_short_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_valid || wr_en) && !bl8_eff) |-> (beat_idx < 3'd4));

  // R4: index rests at zero outside windows
  p_beat_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid || wr_en) |-> (beat_idx == 3'd0));

  // R5: a conflict pulse follows an accepted data command
  p_conflict_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> $past(cmd_valid && cmd_ready && cmd_op[1]));

  // R8: latency held while work stays outstanding
  p_lat_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && $past(!idle)) |-> $stable(rd_lat));

  // R7: an idle block always takes commands
  p_idle_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> cmd_ready);
endmodule

bind ddr2_cas_scheduler ddr2_cas_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .rd_valid(rd_valid), .wr_en(wr_en), .beat_idx(beat_idx),
  .conflict(conflict), .bl8_eff(bl8_eff), .idle(idle), .rd_lat(rd_lat)
);

// File: tb/ddr2_cas_scheduler_bench.sv
module ddr2_cas_scheduler_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [2:0] cfg_al = 3'd0;
  logic [2:0] cfg_cl = 3'd3;
  logic       cfg_bl8 = 1'b0;
  logic       rd_valid, wr_en, conflict;
  logic [2:0] beat_idx;

  ddr2_cas_scheduler u_ddr2_cas_scheduler (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_bl8(cfg_bl8),
    .rd_valid(rd_valid), .wr_en(wr_en), .beat_idx(beat_idx), .conflict(conflict)
  );

  always #10 clk = ~clk;  // 50 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  bit exp_rd [64];
  bit exp_wr [64];
  bit exp_cf [64];
  int exp_bt [64];
  int occ_end [4];
  bit occ_v [4];
  int m_al = 0, m_cl = 3;
  bit m_bl8 = 1'b0;
  int rd_seen, wr_seen, cf_seen, first_rd, first_wr;
  bit last_ready;

  task automatic check(input string req, input int act, input int exp_v, input string what);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d cycle=%0d", req, what, act, exp_v, cyc);
    end
  endtask

  task automatic clear_seen();
    rd_seen = 0; wr_seen = 0; cf_seen = 0; first_rd = -1; first_wr = -1;
  endtask

  function automatic int lat_of(input int al, input int cl, input bit wr);
    int c = (cl < 2) ? 2 : cl;
    return al + c - (wr ? 1 : 0);
  endfunction

  // One cycle: check outputs of the current cycle, then drive the next inputs.
  task automatic step(input bit v, input int op, input int al, input int cl, input bit bl8);
    int c, idx, n, k, lat, blen;
    bit hit;
    @(negedge clk);
    c = cyc;
    idx = c % 64;
    check("R1", int'(rd_valid), int'(exp_rd[idx]), "rd_valid");
    check("R2", int'(wr_en), int'(exp_wr[idx]), "wr_en");
    check("R4", int'(beat_idx), exp_bt[idx], "beat_idx");
    check("R5", int'(conflict), int'(exp_cf[idx]), "conflict");
    if (rd_valid) begin rd_seen++; if (first_rd < 0) first_rd = c; end
    if (wr_en) begin wr_seen++; if (first_wr < 0) first_wr = c; end
    if (conflict) cf_seen++;
    exp_rd[idx] = 0; exp_wr[idx] = 0; exp_cf[idx] = 0; exp_bt[idx] = 0;
    n = 0;
    for (int i = 0; i < 4; i++) begin
      if (occ_v[i] && occ_end[i] < c) occ_v[i] = 0;
      if (occ_v[i]) n++;
    end
    check("R7", int'(cmd_ready), (n < 4) ? 1 : 0, "cmd_ready");
    last_ready = cmd_ready;
    cfg_al = 3'(al); cfg_cl = 3'(cl); cfg_bl8 = bl8;
    if (n == 0) begin m_al = al; m_cl = cl; m_bl8 = bl8; end
    cmd_valid = v; cmd_op = 2'(op);
    if (v && n < 4 && op >= 2) begin
      k = c + 1;
      lat = lat_of(m_al, m_cl, op == 3);
      blen = m_bl8 ? 4 : 2;
      hit = 0;
      for (int j = 0; j < blen; j++)
        if (exp_rd[(k + lat + j) % 64] || exp_wr[(k + lat + j) % 64]) hit = 1;
      if (hit) exp_cf[k % 64] = 1;
      else begin
        for (int j = 0; j < blen; j++) begin
          if (op == 3) exp_wr[(k + lat + j) % 64] = 1;
          else         exp_rd[(k + lat + j) % 64] = 1;
          exp_bt[(k + lat + j) % 64] = 2 * j;
        end
        for (int i = 0; i < 4; i++)
          if (!occ_v[i]) begin occ_v[i] = 1; occ_end[i] = k + lat + blen - 1; break; end
      end
    end
  endtask

  task automatic idle_cycles(input int n, input int al, input int cl, input bit bl8);
    for (int i = 0; i < n; i++) step(0, 0, al, cl, bl8);
  endtask

  initial begin
    int c0, al, cl;
    bit bl8;
    void'($urandom(32'd2718));
    for (int i = 0; i < 64; i++) begin
      exp_rd[i] = 0; exp_wr[i] = 0; exp_cf[i] = 0; exp_bt[i] = 0;
    end
    for (int i = 0; i < 4; i++) occ_v[i] = 0;
    clear_seen();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check("R10", int'(rd_valid), 0, "rd_valid in reset");
    check("R10", int'(wr_en), 0, "wr_en in reset");
    check("R10", int'(conflict), 0, "conflict in reset");
    check("R10", int'(beat_idx), 0, "beat_idx in reset");
    check("R10", int'(cmd_ready), 1, "cmd_ready in reset");
    rst_n = 1'b1;

    // R1 R2 R3 R6: AL=2 CL=3 burst 8, write placed right after read data
    idle_cycles(2, 2, 3, 1);
    clear_seen();
    c0 = cyc + 1;
    step(1, 2, 2, 3, 1);
    idle_cycles(4, 2, 3, 1);
    step(1, 3, 2, 3, 1);
    idle_cycles(14, 2, 3, 1);
    check("R1", first_rd, c0 + 6, "first read cycle");
    check("R3", rd_seen, 4, "read window length burst 8");
    check("R2", first_wr, c0 + 10, "first write cycle");
    check("R6", wr_seen, 4, "adjacent write window length");
    check("R6", cf_seen, 0, "adjacent write conflict");

    // R5: write colliding with read data is dropped
    clear_seen();
    step(1, 2, 0, 3, 0);
    step(1, 3, 0, 3, 0);
    idle_cycles(10, 0, 3, 0);
    check("R5", cf_seen, 1, "conflict pulses");
    check("R5", wr_seen, 0, "dropped write window");
    check("R3", rd_seen, 2, "read window length burst 4");

    // R8: settings changed while busy are ignored
    clear_seen();
    c0 = cyc + 1;
    step(1, 2, 0, 3, 0);
    idle_cycles(2, 4, 7, 1);
    step(1, 3, 4, 7, 1);
    idle_cycles(10, 4, 7, 1);
    check("R8", first_wr, c0 + 6, "write used held latency");
    check("R8", wr_seen, 2, "write used held burst length");

    // R9: activate and no-op produce nothing
    clear_seen();
    step(1, 1, 0, 3, 0);
    step(1, 0, 0, 3, 0);
    idle_cycles(15, 0, 3, 0);
    check("R9", rd_seen + wr_seen + cf_seen, 0, "activity after activate/no-op");

    // R7: four reads outstanding close the stream
    for (int i = 0; i < 4; i++) begin
      step(1, 2, 4, 7, 1);
      idle_cycles(3, 4, 7, 1);
    end
    check("R7", int'(last_ready), 0, "ready with four outstanding");
    idle_cycles(25, 4, 7, 1);

    // R1 clamp: CL below two counts as two
    clear_seen();
    c0 = cyc + 1;
    step(1, 2, 1, 0, 0);
    idle_cycles(8, 1, 0, 0);
    check("R1", first_rd, c0 + 4, "clamped CAS latency");

    // Random traffic
    al = 0; cl = 3; bl8 = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 8 == 0) begin
        al = $urandom % 5; cl = $urandom % 8; bl8 = 1'($urandom % 2);
      end
      step(($urandom % 10) < 6, $urandom % 4, al, cl, bl8);
    end
    idle_cycles(30, al, cl, bl8);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL R7 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule